// File: doc/BRIEF.md
# Card Host Status and Interrupt Controller

This block keeps the event and condition state of a memory-card host controller in one 32-bit status word, holds a 19-bit interrupt enable word, and drives one interrupt request plus one wake-up request toward the system. Event pulses from the command path, the data path, the buffers and card detection set sticky status bits. Those bits stay set until software clears them by writing ones to their positions. The remaining status positions follow live conditions: buffer fill flags, ready flags, the card clock state and a 2-bit write-CRC result code.

Software reads the status word, clears only the events it has handled, and programs the enable word. The enable positions do not match the status positions. Each enable bit selects one status source. Three separate enables route card removal, card insertion and SDIO activity to the wake-up output instead of the interrupt. The interrupt and wake-up outputs are registered, so they are free of glitches and appear one clock after the status word.

Top module: `sdhc_irq_ctrl`

## Requirements
- R1: While `rst` is high, at every clock `status_o`, `ien_o`, `irq_o` and `wake_o` become zero.
- R2: A one on `event_i` at a sticky position sets that status bit at the next clock, and the bit stays set with no further pulse. The sticky positions are 31 (card inserted), 30 (card removed), 25 (underrun), 24 (overflow), 14 (SDIO active), 13 (command response ended), 12 (write done) and 11 (read/transfer done).
- R3: When `stat_wr_i` is high, a one in `stat_wdata_i` clears the matching sticky status bit. A zero leaves it unchanged.
- R4: If an event and a software clear hit the same sticky bit in the same cycle, the bit ends up set.
- R5: Level positions are sampled from the inputs at each clock and ignore software writes: [29:26] from `buf_flags_i`, [10:9] from `wcrc_code_i` (value 2 means no CRC token came back), 8 from `card_clk_run_i`, 7 from `rd_ready_i`, 6 from `wr_ready_i`.
- R6: Status bit 4 and bits [23:15] always read zero. `event_i` has no effect at non-sticky positions.
- R7: When `ien_wr_i` is high, `ien_o` loads `ien_wdata_i` at the next clock. Only positions 0 to 4 and 12 to 18 are kept, and the other positions read zero.
- R8: `irq_o` is high one clock after any enable/source pair is active. The pairs, given as enable bit to status bit, are 0→11, 1→12, 2→13, 3→6, 4→7, 13→14, 14→30, 15→31.
- R9: Enable bit 12 makes `irq_o` follow `dat0_i`, one clock later.
- R10: `wake_o` is high one clock after any of these pairs is active: enable 16 with status 30, enable 17 with status 31, enable 18 with status 14. These enables do not drive `irq_o`.
- R11: The error bits 5 (response CRC), 3 (read CRC), 2 (write CRC), 1 (response timeout) and 0 (read timeout), mask 0x2f, are sticky and write-one-to-clear like R2 and R3. No enable selects them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| event_i | input | 32 | Event pulses at status positions |
| buf_flags_i | input | 4 | Buffer empty/full flags, mapped to status [29:26] |
| wcrc_code_i | input | 2 | Write-CRC result code |
| card_clk_run_i | input | 1 | Card clock running |
| rd_ready_i | input | 1 | Buffer ready for reading |
| wr_ready_i | input | 1 | Buffer ready for writing |
| dat0_i | input | 1 | DAT0 line level |
| stat_wr_i | input | 1 | Status write-one-to-clear strobe |
| stat_wdata_i | input | 32 | Clear mask |
| ien_wr_i | input | 1 | Enable word write strobe |
| ien_wdata_i | input | 19 | Enable word write data |
| status_o | output | 32 | Status word |
| ien_o | output | 19 | Enable word |
| irq_o | output | 1 | Registered interrupt request |
| wake_o | output | 1 | Registered wake-up request |

## Verification
The assertions check on every cycle that sticky bits never fall without a write, that events always land, that level bits track their inputs one clock later, that reserved positions stay zero, and that neither request fires while its enables are clear. Only the bench scenarios can show the exact enable-to-source routing, the set-over-clear priority and DAT0 gating, and that wake enables stay out of the interrupt. The bench shows these by comparing every output on every clock with a behavioural model under targeted stimulus.

// File: rtl/sdhc_irq_pkg.sv
package sdhc_irq_pkg;

    localparam int STAT_W = 32;
    localparam int IEN_W  = 19;

    // status positions decoded by neighbouring logic and software
    localparam int ST_INSERT   = 31;
    localparam int ST_REMOVE   = 30;
    localparam int ST_UNDERRUN = 25;
    localparam int ST_OVERFLOW = 24;
    localparam int ST_SDIO     = 14;
    localparam int ST_CMD_END  = 13;
    localparam int ST_WR_DONE  = 12;
    localparam int ST_RD_DONE  = 11;
    localparam int ST_CLK_RUN  = 8;
    localparam int ST_RD_RDY   = 7;
    localparam int ST_WR_RDY   = 6;

    localparam logic [STAT_W-1:0] STICKY_MASK = 32'hC300_782F;
    localparam logic [STAT_W-1:0] LEVEL_MASK  = 32'h3C00_07C0;
    localparam logic [STAT_W-1:0] ERROR_MASK  = 32'h0000_002F;
    localparam logic [IEN_W-1:0]  IEN_IMPL    = 19'h7_F01F;

    // routing codes returned by ien_source
    localparam int SRC_NONE = -2;
    localparam int SRC_DAT0 = -1;

    typedef struct packed {
        logic [3:0] buf_flags;
        logic [1:0] wcrc_code;
        logic       clk_run;
        logic       rd_rdy;
        logic       wr_rdy;
    } level_t;

    typedef struct packed {
        logic irq;
        logic wake;
    } req_t;

    // status index watched by an enable bit
    function automatic int ien_source(input int en_bit);
        case (en_bit)
            0:       return ST_RD_DONE;
            1:       return ST_WR_DONE;
            2:       return ST_CMD_END;
            3:       return ST_WR_RDY;
            4:       return ST_RD_RDY;
            12:      return SRC_DAT0;
            13:      return ST_SDIO;
            14:      return ST_REMOVE;
            15:      return ST_INSERT;
            16:      return ST_REMOVE;
            17:      return ST_INSERT;
            18:      return ST_SDIO;
            default: return SRC_NONE;
        endcase
    endfunction

    // enable bits that feed the wake-up request
    function automatic bit ien_is_wake(input int en_bit);
        return (en_bit >= 16) && (en_bit <= 18);
    endfunction

    function automatic logic [STAT_W-1:0] place_levels(input level_t l);
        logic [STAT_W-1:0] v;
        v = '0;
        v[29:26]      = l.buf_flags;
        v[10:9]       = l.wcrc_code;
        v[ST_CLK_RUN] = l.clk_run;
        v[ST_RD_RDY]  = l.rd_rdy;
        v[ST_WR_RDY]  = l.wr_rdy;
        return v;
    endfunction

endpackage

// File: rtl/sdhc_stat_reg.sv
module sdhc_stat_reg
    import sdhc_irq_pkg::*;
#(
    parameter int                W   = STAT_W,
    parameter logic [W-1:0]      STK = STICKY_MASK,
    parameter logic [W-1:0]      LVL = LEVEL_MASK
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] lvl_i,
    input  logic         clr_en_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] stat_o
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        if (STK[b]) begin : g_sticky
            logic q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= 1'b0;
                else if (set_i[b])
                    q <= 1'b1;
                else if (clr_en_i && clr_i[b])
                    q <= 1'b0;
            end
            assign stat_o[b] = q;
        end else if (LVL[b]) begin : g_level
            logic q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= 1'b0;
                else
                    q <= lvl_i[b];
            end
            assign stat_o[b] = q;
        end else begin : g_zero
            assign stat_o[b] = 1'b0;
        end
    end

    logic unused_inputs;
    assign unused_inputs = ^(set_i & ~STK) ^ ^(clr_i & ~STK) ^ ^(lvl_i & ~LVL);

endmodule

// File: rtl/sdhc_ien_reg.sv
module sdhc_ien_reg
    import sdhc_irq_pkg::*;
#(
    parameter int           W    = IEN_W,
    parameter logic [W-1:0] IMPL = IEN_IMPL
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] ien_o
);

    for (genvar b = 0; b < W; b++) begin : g_en
        if (IMPL[b]) begin : g_impl
            logic q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= 1'b0;
                else if (wr_i)
                    q <= wdata_i[b];
            end
            assign ien_o[b] = q;
        end else begin : g_none
            assign ien_o[b] = 1'b0;
        end
    end

    logic unused_wdata;
    assign unused_wdata = ^(wdata_i & ~IMPL);

endmodule

// File: rtl/sdhc_irq_merge.sv
module sdhc_irq_merge
    import sdhc_irq_pkg::*;
#(
    parameter int SW = STAT_W,
    parameter int EW = IEN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] stat_i,
    input  logic [EW-1:0] ien_i,
    input  logic          dat0_i,
    output req_t          req_o
);

    logic [EW-1:0] irq_term;
    logic [EW-1:0] wake_term;

    for (genvar e = 0; e < EW; e++) begin : g_term
        localparam int SRC = ien_source(e);
        if (SRC == SRC_DAT0) begin : g_dat0
            assign irq_term[e]  = ien_i[e] & dat0_i;
            assign wake_term[e] = 1'b0;
        end else if (SRC < 0) begin : g_off
            assign irq_term[e]  = 1'b0;
            assign wake_term[e] = 1'b0;
        end else if (ien_is_wake(e)) begin : g_wake
            assign irq_term[e]  = 1'b0;
            assign wake_term[e] = ien_i[e] & stat_i[SRC];
        end else begin : g_irq
            assign irq_term[e]  = ien_i[e] & stat_i[SRC];
            assign wake_term[e] = 1'b0;
        end
    end

    req_t req_d;
    assign req_d.irq  = |irq_term;
    assign req_d.wake = |wake_term;

    always_ff @(posedge clk) begin
        if (rst)
            req_o <= '0;
        else
            req_o <= req_d;
    end

    logic unused_stat;
    assign unused_stat = ^stat_i;

endmodule

// File: rtl/sdhc_irq_ctrl.sv
module sdhc_irq_ctrl
    import sdhc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] event_i,
    input  logic [3:0]        buf_flags_i,
    input  logic [1:0]        wcrc_code_i,
    input  logic              card_clk_run_i,
    input  logic              rd_ready_i,
    input  logic              wr_ready_i,
    input  logic              dat0_i,
    input  logic              stat_wr_i,
    input  logic [STAT_W-1:0] stat_wdata_i,
    input  logic              ien_wr_i,
    input  logic [IEN_W-1:0]  ien_wdata_i,
    output logic [STAT_W-1:0] status_o,
    output logic [IEN_W-1:0]  ien_o,
    output logic              irq_o,
    output logic              wake_o
);

    level_t            lvl;
    logic [STAT_W-1:0] lvl_vec;
    req_t              req;

    assign lvl.buf_flags = buf_flags_i;
    assign lvl.wcrc_code = wcrc_code_i;
    assign lvl.clk_run   = card_clk_run_i;
    assign lvl.rd_rdy    = rd_ready_i;
    assign lvl.wr_rdy    = wr_ready_i;
    assign lvl_vec       = place_levels(lvl);

    sdhc_stat_reg #(
        .W   (STAT_W),
        .STK (STICKY_MASK),
        .LVL (LEVEL_MASK)
    ) u_stat (
        .clk      (clk),
        .rst      (rst),
        .set_i    (event_i),
        .lvl_i    (lvl_vec),
        .clr_en_i (stat_wr_i),
        .clr_i    (stat_wdata_i),
        .stat_o   (status_o)
    );

    sdhc_ien_reg #(
        .W    (IEN_W),
        .IMPL (IEN_IMPL)
    ) u_ien (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (ien_wr_i),
        .wdata_i (ien_wdata_i),
        .ien_o   (ien_o)
    );

    sdhc_irq_merge #(
        .SW (STAT_W),
        .EW (IEN_W)
    ) u_merge (
        .clk    (clk),
        .rst    (rst),
        .stat_i (status_o),
        .ien_i  (ien_o),
        .dat0_i (dat0_i),
        .req_o  (req)
    );

    assign irq_o  = req.irq;
    assign wake_o = req.wake;

endmodule

// File: rtl/sdhc_irq_ctrl_chk.sv
module sdhc_irq_ctrl_chk
    import sdhc_irq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [STAT_W-1:0] event_i,
    input logic [3:0]        buf_flags_i,
    input logic              stat_wr_i,
    input logic [STAT_W-1:0] stat_wdata_i,
    input logic [STAT_W-1:0] status_o,
    input logic [IEN_W-1:0]  ien_o,
    input logic              irq_o,
    input logic              wake_o
);

    logic up_q;
    always_ff @(posedge clk) begin
        if (rst) up_q <= 1'b0;
        else     up_q <= 1'b1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (status_o == '0 && ien_o == '0 && !irq_o && !wake_o)); // R1

    AST_EVENT_LANDS: assert property (@(posedge clk) disable iff (rst)
        (|(event_i & STICKY_MASK)) |=>
            ((status_o & $past(event_i & STICKY_MASK)) == $past(event_i & STICKY_MASK))); // R2

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        !stat_wr_i |=> ((($past(status_o) & ~status_o) & STICKY_MASK) == '0)); // R2

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (stat_wr_i && stat_wdata_i[ST_CMD_END] && !event_i[ST_CMD_END]) |=> !status_o[ST_CMD_END]); // R3

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (stat_wr_i && stat_wdata_i[ST_RD_DONE] && event_i[ST_RD_DONE]) |=> status_o[ST_RD_DONE]); // R4

    AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (rst)
        up_q |-> (status_o[29:26] == $past(buf_flags_i))); // R5

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (status_o & ~(STICKY_MASK | LEVEL_MASK)) == '0); // R6

    AST_IEN_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (ien_o & ~IEN_IMPL) == '0); // R7

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        (up_q && $past(ien_o[15:0] == '0)) |-> !irq_o); // R8

    AST_IRQ_CMD_END: assert property (@(posedge clk) disable iff (rst)
        (up_q && $past(status_o[ST_CMD_END] && ien_o[2])) |-> irq_o); // R8

    AST_WAKE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        (up_q && $past(ien_o[18:16] == '0)) |-> !wake_o); // R10

endmodule

bind sdhc_irq_ctrl sdhc_irq_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .event_i      (event_i),
    .buf_flags_i  (buf_flags_i),
    .stat_wr_i    (stat_wr_i),
    .stat_wdata_i (stat_wdata_i),
    .status_o     (status_o),
    .ien_o        (ien_o),
    .irq_o        (irq_o),
    .wake_o       (wake_o)
);

// File: tb/sdhc_irq_ctrl_bench.sv
`timescale 1ns/1ps
module sdhc_irq_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ev = '0;
    logic [3:0]  bufs = '0;
    logic [1:0]  wcrc = '0;
    logic        clkrun = 1'b0, rdr = 1'b0, wrr = 1'b0, dat0 = 1'b0;
    logic        swr = 1'b0;
    logic [31:0] swd = '0;
    logic        ienw = 1'b0;
    logic [18:0] iend = '0;
    logic [31:0] status;
    logic [18:0] ien;
    logic        irq, wake;

    always #2 clk = ~clk;

    sdhc_irq_ctrl u_sdhc_irq_ctrl (
        .clk(clk), .rst(rst), .event_i(ev), .buf_flags_i(bufs), .wcrc_code_i(wcrc),
        .card_clk_run_i(clkrun), .rd_ready_i(rdr), .wr_ready_i(wrr), .dat0_i(dat0),
        .stat_wr_i(swr), .stat_wdata_i(swd), .ien_wr_i(ienw), .ien_wdata_i(iend),
        .status_o(status), .ien_o(ien), .irq_o(irq), .wake_o(wake)
    );

    localparam logic [31:0] STK  = 32'hC300_782F;
    localparam logic [18:0] IMPL = 19'h7_F01F;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    logic [31:0] m_stat = '0;
    logic [18:0] m_ien = '0;
    logic        m_irq = 1'b0, m_wake = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        logic [31:0] ns, clr;
        logic [18:0] ni;
        logic        nirq, nwake;
        @(posedge clk);
        if (rst) begin
            m_stat = '0; m_ien = '0; m_irq = 1'b0; m_wake = 1'b0;
        end else begin
            nirq  = (m_ien[0] & m_stat[11]) | (m_ien[1] & m_stat[12]) | (m_ien[2] & m_stat[13])
                  | (m_ien[3] & m_stat[6])  | (m_ien[4] & m_stat[7])  | (m_ien[12] & dat0)
                  | (m_ien[13] & m_stat[14]) | (m_ien[14] & m_stat[30]) | (m_ien[15] & m_stat[31]);
            nwake = (m_ien[16] & m_stat[30]) | (m_ien[17] & m_stat[31]) | (m_ien[18] & m_stat[14]);
            clr = swr ? swd : 32'h0;
            ns = ((m_stat & ~clr) | ev) & STK;
            ns[29:26] = bufs; ns[10:9] = wcrc; ns[8] = clkrun; ns[7] = rdr; ns[6] = wrr;
            ni = ienw ? (iend & IMPL) : m_ien;
            m_stat = ns; m_ien = ni; m_irq = nirq; m_wake = nwake;
        end
        @(negedge clk);
        chk("R2 status", status, m_stat);
        chk("R7 enable", {13'h0, ien}, {13'h0, m_ien});
        chk("R8 irq", {31'h0, irq}, {31'h0, m_irq});
        chk("R10 wake", {31'h0, wake}, {31'h0, m_wake});
    endtask

    task automatic idle();
        ev = '0; swr = 1'b0; swd = '0; ienw = 1'b0; iend = '0;
    endtask

    task automatic clear_all();
        swr = 1'b1; swd = 32'hFFFF_FFFF; step(); idle();
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset holds everything at zero even with activity at the inputs
        ev = 32'hFFFF_FFFF; bufs = 4'hF; dat0 = 1'b1; ienw = 1'b1; iend = 19'h7FFFF;
        repeat (3) step();
        chk("R1 reset status", status, 32'h0);
        chk("R1 reset irq", {31'h0, irq}, 32'h0);
        idle(); bufs = '0; dat0 = 1'b0;
        rst = 1'b0;
        step();

        // R2: command-end pulse sets and holds
        ev = 32'h0000_2000; step(); idle();
        chk("R2 set", status, 32'h0000_2000);
        repeat (3) step();
        chk("R2 hold", status, 32'h0000_2000);

        // R3: zeros do nothing, ones clear
        swr = 1'b1; swd = 32'h0; step(); idle();
        chk("R3 write zero", status, 32'h0000_2000);
        swr = 1'b1; swd = 32'h0000_2000; step(); idle();
        chk("R3 write one", status, 32'h0);

        // R4: set beats clear
        ev = 32'h0000_0800; swr = 1'b1; swd = 32'h0000_0800; step(); idle();
        chk("R4 priority", status, 32'h0000_0800);
        clear_all();

        // R11: error bits sticky, never reach irq
        ev = 32'h0000_002F; step(); idle();
        chk("R11 errors", status, 32'h0000_002F);
        ienw = 1'b1; iend = 19'h0_F01F; step(); idle();
        step();
        chk("R11 no irq", {31'h0, irq}, 32'h0);
        swr = 1'b1; swd = 32'h0000_0005; step(); idle();
        chk("R11 partial clear", status, 32'h0000_002A);
        clear_all();
        ienw = 1'b1; iend = '0; step(); idle();

        // R5: levels follow inputs and ignore writes
        bufs = 4'b1010; wcrc = 2'd2; clkrun = 1'b1; step();
        chk("R5 levels", status, 32'h2800_0500);
        swr = 1'b1; swd = 32'hFFFF_FFFF; step(); idle();
        chk("R5 ignore write", status, 32'h2800_0500);
        bufs = '0; wcrc = '0; clkrun = 1'b0; step();
        chk("R5 release", status, 32'h0);

        // R6: pulses on reserved and level positions have no effect
        ev = 32'h3CFF_87D0; step(); idle();
        chk("R6 reserved", status, 32'h0);

        // R7: enable write keeps only implemented bits
        ienw = 1'b1; iend = 19'h7FFFF; step(); idle();
        chk("R7 ien mask", {13'h0, ien}, 32'h0007_F01F);
        ienw = 1'b1; iend = 19'h0_0004; step(); idle();

        // R8: command-end routed through enable bit 2, one clock after status
        ev = 32'h0000_2000; step(); idle();
        chk("R8 irq not yet", {31'h0, irq}, 32'h0);
        step();
        chk("R8 irq", {31'h0, irq}, 32'h1);
        swr = 1'b1; swd = 32'h0000_2000; step(); idle();
        step();
        chk("R8 irq drop", {31'h0, irq}, 32'h0);
        ienw = 1'b1; iend = 19'h0_0010; step(); idle();
        rdr = 1'b1; step(); step();
        chk("R8 read ready", {31'h0, irq}, 32'h1);
        rdr = 1'b0; wrr = 1'b1; step(); step();
        chk("R8 write ready masked", {31'h0, irq}, 32'h0);
        wrr = 1'b0;
        ienw = 1'b1; iend = 19'h0_8000; step(); idle();
        ev = 32'h8000_0000; step(); idle(); step();
        chk("R8 insertion", {31'h0, irq}, 32'h1);
        clear_all();

        // R9: DAT0 gated by enable 12
        ienw = 1'b1; iend = 19'h0_1000; step(); idle();
        dat0 = 1'b1; step();
        chk("R9 dat0", {31'h0, irq}, 32'h1);
        dat0 = 1'b0; step();
        chk("R9 dat0 low", {31'h0, irq}, 32'h0);

        // R10: wake enables route removal to wake only
        ienw = 1'b1; iend = 19'h1_0000; step(); idle();
        ev = 32'h4000_0000; step(); idle(); step();
        chk("R10 wake", {31'h0, wake}, 32'h1);
        chk("R10 no irq", {31'h0, irq}, 32'h0);
        ienw = 1'b1; iend = 19'h4_0000; step(); idle();
        ev = 32'h0000_4000; step(); idle(); step();
        chk("R10 sdio wake", {31'h0, wake}, 32'h1);
        clear_all(); step();
        chk("R10 wake drop", {31'h0, wake}, 32'h0);

        // mixed traffic
        for (int k = 0; k < 40; k++) begin
            ev = (32'h1 << (k % 32)) | (32'h1 << ((k * 7) % 32));
            swr = k[0]; swd = 32'h1 << ((k * 3) % 32);
            ienw = (k % 5 == 0); iend = 19'h1 << (k % 19);
            dat0 = k[1]; rdr = k[2]; bufs = k[3:0];
            step();
        end
        idle(); dat0 = 1'b0; rdr = 1'b0; bufs = '0;
        step(); step();

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule